// File: doc/BRIEF.md
# Self-Starting Pseudo-Random Shift Register

This block produces a stream of pseudo-random 7-bit values for the logic that times a random delay. It is a Fibonacci shift register that advances once on every clock where its enable is high. On each advance the value moves one place toward the most significant end. The new bit that enters at the bottom is the XOR of the two highest bits.

An all-zero value is normally a trap for this kind of register. Here a zero detector forces the incoming bit to 1 whenever the whole register is zero. The register therefore leaves zero by itself on its first enabled clock, and it does not depend on a power-up value that hardware may never apply. A synchronous active-high reset is provided for systems that want a known starting point. The value it loads is a parameter whose default is 7'h01.

The output is taken straight from the state flops. Once the register holds a nonzero value, it walks through all 127 nonzero values and then repeats.

Top module: `selfstart_lfsr`

## Requirements
- R1: While `rst` is high at a rising clock edge, the register loads RESET_VALUE (default 7'h01). The loaded value is visible on `value` after that edge.
- R2: With `rst` low and `en` low at a rising edge, `value` keeps its previous contents.
- R3: With `rst` low, `en` high and a nonzero `value`, the next value is {value[5:0], value[6] ^ value[5]}. Bit 6 is the most significant bit.
- R4: With `rst` low, `en` high and `value` equal to 7'h00, the next value is 7'h01. This holds whatever the register started from, including a reset value of zero.
- R5: Once `value` is nonzero, enabled steps never bring it back to zero.
- R6: Starting from 7'h01, 127 enabled steps visit every nonzero 7-bit value exactly once and return to 7'h01.
- R7: `rst` takes priority over `en` when both are high at the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset; loads RESET_VALUE |
| en | input | 1 | Advance the register by one step |
| value | output | WIDTH (7) | Current register contents, driven directly by flops |

## Verification
The most important corner is the zero state. A second instance in the bench has its reset value set to zero, so the zero state can be reached through the ports. A design that lost the zero detector would keep that instance at zero for ever. The bench also runs a full 127-step cycle from 7'h01. A feedback tap on the wrong bit would end the cycle early or repeat a value, and the count of distinct values would show it. Further checks hold `en` low between steps and raise `rst` and `en` together. These catch a register that drifts while it should hold, and a reset that loses to the enable.

// File: rtl/lfsr_pkg.sv
package lfsr_pkg;

  // Default geometry: a 7-bit register with taps on the two top bits,
  // which gives a maximal-length sequence of 127 nonzero values.
  localparam int unsigned DEF_WIDTH  = 7;
  localparam int unsigned DEF_TAP_HI = 6;
  localparam int unsigned DEF_TAP_LO = 5;

  // Returns 1 when both tap positions lie inside the register and are distinct.
  function automatic bit taps_valid(input int unsigned width,
                                    input int unsigned hi,
                                    input int unsigned lo);
    return (hi < width) && (lo < width) && (hi != lo);
  endfunction

endpackage

// File: rtl/lfsr_feedback.sv
// Computes the bit that enters at position 0. The bit is the XOR of the two
// taps, ORed with a detector that is high only when the whole register is zero.
module lfsr_feedback #(
  parameter int unsigned WIDTH  = lfsr_pkg::DEF_WIDTH,
  parameter int unsigned TAP_HI = lfsr_pkg::DEF_TAP_HI,
  parameter int unsigned TAP_LO = lfsr_pkg::DEF_TAP_LO
) (
  input  logic [WIDTH-1:0] state_i,
  output logic             fb_o,
  output logic             is_zero_o
);

  logic tap_xor;

  // The NOR over every bit keeps the register from locking at zero.
  assign is_zero_o = ~(|state_i);
  assign tap_xor   = state_i[TAP_HI] ^ state_i[TAP_LO];
  assign fb_o      = tap_xor | is_zero_o;

endmodule

// File: rtl/lfsr_state_reg.sv
// The state flops. Reset has priority; the enable gates each shift.
module lfsr_state_reg #(
  parameter int unsigned    WIDTH       = lfsr_pkg::DEF_WIDTH,
  parameter logic [WIDTH-1:0] RESET_VALUE = {{(WIDTH-1){1'b0}}, 1'b1}
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             fb_i,
  output logic [WIDTH-1:0] state_o
);

  logic [WIDTH-1:0] shifted;

  // One-place move toward the MSB, with the feedback bit at the bottom.
  assign shifted = {state_o[WIDTH-2:0], fb_i};

  always_ff @(posedge clk) begin
    if (rst)
      state_o <= RESET_VALUE;
    else if (en)
      state_o <= shifted;
  end

endmodule

// File: rtl/selfstart_lfsr.sv
// Top level: a Fibonacci shift register that starts itself from the zero state.
module selfstart_lfsr #(
  parameter int unsigned      WIDTH       = lfsr_pkg::DEF_WIDTH,
  parameter int unsigned      TAP_HI      = lfsr_pkg::DEF_TAP_HI,
  parameter int unsigned      TAP_LO      = lfsr_pkg::DEF_TAP_LO,
  parameter logic [WIDTH-1:0] RESET_VALUE = {{(WIDTH-1){1'b0}}, 1'b1}
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  output logic [WIDTH-1:0] value
);

  logic             fb;
  logic             at_zero;
  logic [WIDTH-1:0] state;

  // Stop elaboration if a tap points outside the register or both taps coincide.
  generate
    if (!lfsr_pkg::taps_valid(WIDTH, TAP_HI, TAP_LO)) begin : g_bad_taps
      $error("selfstart_lfsr: tap positions out of range or equal");
    end
  endgenerate

  lfsr_feedback #(
    .WIDTH (WIDTH),
    .TAP_HI(TAP_HI),
    .TAP_LO(TAP_LO)
  ) u_fb (
    .state_i  (state),
    .fb_o     (fb),
    .is_zero_o(at_zero)
  );

  lfsr_state_reg #(
    .WIDTH      (WIDTH),
    .RESET_VALUE(RESET_VALUE)
  ) u_reg (
    .clk    (clk),
    .rst    (rst),
    .en     (en),
    .fb_i   (fb),
    .state_o(state)
  );

  // The output comes straight from the flops.
  assign value = state;

  logic unused_zero;
  assign unused_zero = at_zero;

endmodule

// File: rtl/selfstart_lfsr_chk.sv
module selfstart_lfsr_chk #(
  parameter int unsigned      WIDTH       = 7,
  parameter int unsigned      TAP_HI      = 6,
  parameter int unsigned      TAP_LO      = 5,
  parameter logic [WIDTH-1:0] RESET_VALUE = 7'h01
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic [WIDTH-1:0] value
);

  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  AST_RESET_LOAD: assert property (@(posedge clk) rst |=> value == RESET_VALUE); // R1 R7
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst) !en |=> $stable(value)); // R2
  AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (rst) (en && value != '0) |=> value == {$past(value[WIDTH-2:0]), $past(value[TAP_HI] ^ value[TAP_LO])}); // R3
  AST_ZERO_ESCAPE: assert property (@(posedge clk) disable iff (rst) (en && value == '0) |=> value == ONE); // R4
  AST_NO_ZERO_RETURN: assert property (@(posedge clk) disable iff (rst) (value != '0) |=> value != '0); // R5

endmodule

bind selfstart_lfsr selfstart_lfsr_chk #(
  .WIDTH      (WIDTH),
  .TAP_HI     (TAP_HI),
  .TAP_LO     (TAP_LO),
  .RESET_VALUE(RESET_VALUE)
) u_chk (
  .clk  (clk),
  .rst  (rst),
  .en   (en),
  .value(value)
);

// File: tb/sim_selfstart_lfsr.sv
`timescale 1ns/1ps
module sim_selfstart_lfsr;

  logic       clk = 1'b0;
  logic       rst = 1'b0;
  logic       en  = 1'b0;
  logic [6:0] val0;
  logic [6:0] val1;

  int unsigned n_checks = 0;
  int unsigned n_fail   = 0;
  bit          done     = 1'b0;

  logic [6:0] exp0_q[$];
  logic [6:0] exp1_q[$];
  string      tag_q[$];

  logic [6:0] m0;
  logic [6:0] m1;
  bit         seen[128];

  always #2 clk = ~clk; // 250 MHz

  // u0 uses the default reset value 7'h01; u1 resets to zero for the zero-escape corner.
  selfstart_lfsr u0 (.clk(clk), .rst(rst), .en(en), .value(val0));
  selfstart_lfsr #(.RESET_VALUE(7'h00)) u1 (.clk(clk), .rst(rst), .en(en), .value(val1));

  // Reference step, written from R3 and R4.
  function automatic logic [6:0] ref_next(input logic [6:0] q);
    if (q == 7'h00) return 7'h01;
    return {q[5:0], q[6] ^ q[5]};
  endfunction

  // Driver: applies one cycle of stimulus and pushes the expected results.
  task automatic drive(input bit r, input bit e, input string tag);
    @(negedge clk);
    rst = r;
    en  = e;
    if (r) begin
      m0 = 7'h01;
      m1 = 7'h00;
    end else if (e) begin
      m0 = ref_next(m0);
      m1 = ref_next(m1);
    end
    exp0_q.push_back(m0);
    exp1_q.push_back(m1);
    tag_q.push_back(tag);
  endtask

  task automatic check(input bit ok, input string tag, input logic [6:0] act, input logic [6:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops one expected item per clock and compares it with both outputs.
  always @(posedge clk) begin
    #1;
    if (tag_q.size() > 0) begin
      logic [6:0] e0;
      logic [6:0] e1;
      string      t;
      e0 = exp0_q.pop_front();
      e1 = exp1_q.pop_front();
      t  = tag_q.pop_front();
      check(val0 == e0, t, val0, e0);
      check(val1 == e1, {t, " (zero-reset instance)"}, val1, e1);
      if (!rst) check(val0 != 7'h00, "R5 nonzero", val0, e0);
      if (t == "R6") seen[val0] = 1'b1;
    end
  end

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog R1 actual=%h expected=%h", val0, m0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    m0 = 7'h01;
    m1 = 7'h00;
    // R1: reset state.
    drive(1, 0, "R1");
    drive(1, 0, "R1");
    // R2: hold with the enable low.
    repeat (4) drive(0, 0, "R2");
    // R4: u1 leaves zero; R3: u0 advances from 7'h01.
    drive(0, 1, "R4");
    drive(0, 1, "R3");
    // R3/R2: an irregular enable pattern.
    for (int i = 0; i < 20; i++) drive(0, (i % 3) != 1, (i % 3) != 1 ? "R3" : "R2");
    // R7: reset wins over the enable.
    drive(1, 1, "R7");
    drive(1, 1, "R7");
    // R6: a full cycle starting from 7'h01.
    for (int i = 0; i < 128; i++) seen[i] = 1'b0;
    for (int i = 0; i < 127; i++) drive(0, 1, "R6");
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    begin
      int distinct;
      distinct = 0;
      for (int i = 1; i < 128; i++) if (seen[i]) distinct++;
      check(distinct == 127, "R6 distinct values", 7'(distinct), 7'd127);
      check(!seen[0], "R6 zero visited", {6'd0, seen[0]}, 7'h00);
      check(val0 == 7'h01, "R6 return to start", val0, 7'h01);
    end
    // A second zero escape after a fresh reset.
    drive(1, 0, "R1");
    drive(0, 1, "R4");
    drive(0, 0, "R2");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule